// File: doc/BRIEF.md
# Sticky Fault Status Register Bank

This block keeps the latched fault and diagnostic flags of a two-channel power stage and hands them to software, one register at a time, through a serial register interface. Each flag follows a live condition input. The flag sets as soon as the condition is seen, and it stays set after the condition goes away. A read of a register clears that register's flags, but only in a controlled way. The clear waits until the serial engine reports that the read response has been fully shifted out. At that moment only the flags that were actually reported and whose condition has since dropped are removed.

The serial engine sends a one-cycle read strobe with a register address. The bank answers with a snapshot of that register on `rd_data_o`, which is valid from the cycle after the strobe. Later the engine pulses the end-of-response strobe, and the bank then clears that register's flags under the rules above. A logic-supply undervoltage is modelled as the asynchronous reset. This reset returns every flag to its default and leaves the power-cycle flag set. The input-supply lockout conditions have no readable flag and do not enter this block. A one-wire summary output tells the system whether any flag or event count is pending.

Top module: `fsb_status_bank`

## Requirements
- R1: A condition input that is high at a rising clock edge sets its flag at that edge. The flag is seen by any read command issued from the next cycle on.
- R2: A set flag stays set through any number of cycles, and through read commands, until a completed read of its register clears it.
- R3: A read command alone clears nothing. Flags are cleared only at the edge where `rsp_end_i` is high while a read is pending, and only in the register that the pending read addressed.
- R4: At that edge a flag whose condition is still high stays set. A condition pulse that coincides with the clearing edge also leaves the flag set.
- R5: The clear removes only flags that were 1 in the snapshot returned by the pending read. A flag set after the read command survives the clear.
- R6: Register 0 (current limit, short and loop overvoltage) holds channel c in bits [4c+3:4c]. Within that lane, bit 0 is high-side current limit, bit 1 is low-side current limit, bit 2 is output short and bit 3 is COMP overvoltage.
- R7: Register 1 (thermal, bootstrap and duty limit) holds channel c in bits [4c+2:4c]. Within that lane, bit 0 is thermal shutdown, bit 1 is bootstrap undervoltage and bit 2 is minimum off-time. Bits 3 and 7 read 0.
- R8: Register 2 (system) holds bit 0 thermal warning, bit 1 power cycle, bit 2 analog-supply undervoltage and bit 3 communication error. Bits 7:6 read 0. After reset, register 2 reads 0x02 and registers 0 and 1 read 0x00.
- R9: Register 2 bits [5:4] hold a count of `wd_to_i` pulses that saturates at 3. A completed read of register 2 subtracts the count value it reported, and a pulse in the clearing cycle is still counted.
- R10: Address 3 reads 0x00. An `rsp_end_i` with no pending read changes no flag.
- R11: `alert_o` is high exactly when any flag or the event count is non-zero.
- R12: `rd_data_o` takes the addressed register's flags, as held before the read-strobe edge, at that edge. It holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (logic-supply undervoltage) |
| hs_ilim_i | input | NUM_CH | High-side current limit condition per channel |
| ls_ilim_i | input | NUM_CH | Low-side current limit condition per channel |
| short_i | input | NUM_CH | Output short condition per channel |
| comp_ov_i | input | NUM_CH | COMP overvoltage condition per channel |
| tsd_i | input | NUM_CH | Thermal shutdown condition per channel |
| bst_uv_i | input | NUM_CH | Bootstrap undervoltage condition per channel |
| toff_min_i | input | NUM_CH | Minimum off-time condition per channel |
| twarn_i | input | 1 | Thermal warning condition |
| v5a_uv_i | input | 1 | Analog-supply undervoltage condition |
| comm_err_i | input | 1 | Communication error condition |
| wd_to_i | input | 1 | Watchdog timeout event, one pulse per event |
| rd_req_i | input | 1 | Read command strobe |
| rd_addr_i | input | ADDR_W | Register address of the read command |
| rsp_end_i | input | 1 | End of read response strobe |
| rd_data_o | output | DATA_W | Snapshot of the addressed register |
| alert_o | output | 1 | Any flag or event count pending |

## Verification
The assertions check the per-flag rules on every cycle. A high condition is always set one edge later. A set flag drops only at an edge where a clear for it was applied. A clear of a flag whose condition is low always takes effect. The read-data register moves only on a read strobe, and the event count steps by one per event. Other behaviour can be shown only by the directed scenarios. This covers the bit layout of each register and the reset value of the power-cycle flag. It also covers the rule that a clear reaches only the register that was read, and the deferral from command to end of response. The last scenario-only case is the survival of a flag that rose between the snapshot and the clear.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int unsigned NUM_REG  = 3;
  localparam int unsigned REG_ILIM = 0;
  localparam int unsigned REG_THRM = 1;
  localparam int unsigned REG_SYS  = 2;
  // system register flag positions
  localparam int unsigned SYS_TWARN = 0;
  localparam int unsigned SYS_PWRC  = 1;
  localparam int unsigned SYS_V5AUV = 2;
  localparam int unsigned SYS_CERR  = 3;
  localparam int unsigned SYS_NFLG  = 4;
  localparam int unsigned SYS_CNT_LSB = 4;
endpackage

// File: rtl/fsb_sticky_bits.sv
module fsb_sticky_bits #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  // set wins over a coinciding clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= RST_VAL;
    else         flag_q <= cond_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R1
    set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond_i[i] |=> flag_q[i]);
    // R2
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
    // R4
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !cond_i[i]) |=> !flag_q[i]);
    // R5
    fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_q[i]) |-> $past(clr_i[i]));
  end
endmodule

// File: rtl/fsb_evt_cnt.sv
module fsb_evt_cnt #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic [CW-1:0] sub_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, base;

  always_comb base = cnt_q - sub_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (inc_i && (base != '1))    cnt_q <= base + CW'(1);
    else                               cnt_q <= base;
  end

  assign cnt_o = cnt_q;

  // R9
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && sub_i == '0 && cnt_q != '1) |=> cnt_q == $past(cnt_q) + CW'(1));
  // R9
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_i == '0 && cnt_q == '1) |=> cnt_q == '1);
endmodule

// File: rtl/fsb_rd_ctrl.sv
module fsb_rd_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned NREG   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_req_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic                   rsp_end_i,
  input  logic [NREG*DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [NREG*DATA_W-1:0] clr_o
);
  logic [DATA_W-1:0] sel, snap_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;

  always_comb begin
    sel = '0;
    for (int i = 0; i < int'(NREG); i++)
      if (rd_addr_i == ADDR_W'(i)) sel = regs_i[i*DATA_W +: DATA_W];
  end

  // address is captured at command time; clear waits for response end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q      <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (rd_req_i) begin
      snap_q      <= sel;
      pend_q      <= 1'b1;
      pend_addr_q <= rd_addr_i;
    end else if (rsp_end_i) begin
      pend_q      <= 1'b0;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_clr
    assign clr_o[i*DATA_W +: DATA_W] =
      (rsp_end_i && pend_q && pend_addr_q == ADDR_W'(i)) ? snap_q : '0;
  end

  assign rd_data_o = snap_q;

  // R12
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(rd_data_o));
  // R10
  empty_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && rd_addr_i >= ADDR_W'(NREG)) |=> rd_data_o == '0);
  // R3
  no_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_end_i && !rd_req_i) |=> !pend_q);
endmodule

// File: rtl/fsb_status_bank.sv
module fsb_status_bank
  import fsb_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hs_ilim_i,
  input  logic [NUM_CH-1:0] ls_ilim_i,
  input  logic [NUM_CH-1:0] short_i,
  input  logic [NUM_CH-1:0] comp_ov_i,
  input  logic [NUM_CH-1:0] tsd_i,
  input  logic [NUM_CH-1:0] bst_uv_i,
  input  logic [NUM_CH-1:0] toff_min_i,
  input  logic              twarn_i,
  input  logic              v5a_uv_i,
  input  logic              comm_err_i,
  input  logic              wd_to_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rsp_end_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              alert_o
);
  localparam int unsigned LANE_W = DATA_W / NUM_CH;
  localparam int unsigned BANK_W = NUM_REG * DATA_W;
  localparam logic [SYS_NFLG-1:0] SYS_RST = SYS_NFLG'(1 << SYS_PWRC);

  logic [DATA_W-1:0]   cond_ilim, cond_thrm, flag_ilim, flag_thrm, word_sys;
  logic [SYS_NFLG-1:0] cond_sys, flag_sys;
  logic [CNT_W-1:0]    evt_cnt;
  logic [BANK_W-1:0]   regs, clr;

  always_comb begin
    cond_ilim = '0;
    cond_thrm = '0;
    for (int c = 0; c < int'(NUM_CH); c++) begin
      cond_ilim[c*LANE_W +: 4] = {comp_ov_i[c], short_i[c], ls_ilim_i[c], hs_ilim_i[c]};
      cond_thrm[c*LANE_W +: 3] = {toff_min_i[c], bst_uv_i[c], tsd_i[c]};
    end
    cond_sys = '0;
    cond_sys[SYS_TWARN] = twarn_i;
    cond_sys[SYS_V5AUV] = v5a_uv_i;
    cond_sys[SYS_CERR]  = comm_err_i;
  end

  fsb_sticky_bits #(.W(DATA_W), .RST_VAL('0)) u_ilim (
    .clk_i, .rst_ni, .cond_i(cond_ilim),
    .clr_i(clr[REG_ILIM*DATA_W +: DATA_W]), .flag_o(flag_ilim));

  fsb_sticky_bits #(.W(DATA_W), .RST_VAL('0)) u_thrm (
    .clk_i, .rst_ni, .cond_i(cond_thrm),
    .clr_i(clr[REG_THRM*DATA_W +: DATA_W]), .flag_o(flag_thrm));

  fsb_sticky_bits #(.W(SYS_NFLG), .RST_VAL(SYS_RST)) u_sys (
    .clk_i, .rst_ni, .cond_i(cond_sys),
    .clr_i(clr[REG_SYS*DATA_W +: SYS_NFLG]), .flag_o(flag_sys));

  fsb_evt_cnt #(.CW(CNT_W)) u_wdcnt (
    .clk_i, .rst_ni, .inc_i(wd_to_i),
    .sub_i(clr[REG_SYS*DATA_W + SYS_CNT_LSB +: CNT_W]), .cnt_o(evt_cnt));

  always_comb begin
    word_sys = '0;
    word_sys[SYS_NFLG-1:0] = flag_sys;
    word_sys[SYS_CNT_LSB +: CNT_W] = evt_cnt;
    regs = '0;
    regs[REG_ILIM*DATA_W +: DATA_W] = flag_ilim;
    regs[REG_THRM*DATA_W +: DATA_W] = flag_thrm;
    regs[REG_SYS*DATA_W  +: DATA_W] = word_sys;
  end

  fsb_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NUM_REG)) u_rd (
    .clk_i, .rst_ni, .rd_req_i, .rd_addr_i, .rsp_end_i,
    .regs_i(regs), .rd_data_o, .clr_o(clr));

  assign alert_o = |regs;

  // R8
  pwrc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_sys[SYS_PWRC] && !rsp_end_i) |=> flag_sys[SYS_PWRC]);
  // R11
  alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_ilim_i[0] || tsd_i[0] || wd_to_i) |=> alert_o);
endmodule

// File: tb/tb_fsb_status_bank.sv
module tb_fsb_status_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NUM_CH-1:0] hs = '0, ls = '0, sh = '0, cov = '0, tsd = '0, bst = '0, toff = '0;
  logic twarn = 0, v5a = 0, cerr = 0, wdto = 0, rd_req = 0, rsp_end = 0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic alert;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsb_status_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .hs_ilim_i(hs), .ls_ilim_i(ls), .short_i(sh),
    .comp_ov_i(cov), .tsd_i(tsd), .bst_uv_i(bst), .toff_min_i(toff),
    .twarn_i(twarn), .v5a_uv_i(v5a), .comm_err_i(cerr), .wd_to_i(wdto),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rsp_end_i(rsp_end),
    .rd_data_o(rd_data), .alert_o(alert));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    rd_req = 1; rd_addr = a;
    cyc();
    rd_req = 0;
    chk(req, rd_data, exp);
  endtask

  task automatic fin();
    rsp_end = 1;
    cyc();
    rsp_end = 0;
  endtask

  task automatic t_reset();
    chk("R11 alert after reset", {7'b0, alert}, 8'h01);
    rd(2'd0, 8'h00, "R8 reg0 reset");
    rd(2'd1, 8'h00, "R8 reg1 reset");
    rd(2'd2, 8'h02, "R8 reg2 reset power cycle");
    repeat (3) cyc();
    chk("R12 data held", rd_data, 8'h02);
    fin();
    rd(2'd2, 8'h00, "R3 power cycle cleared");
    chk("R11 alert idle", {7'b0, alert}, 8'h00);
  endtask

  task automatic t_layout();
    hs[0] = 1; sh[1] = 1; cyc(); hs = '0; sh = '0;
    rd(2'd0, 8'h41, "R6 R1 reg0 layout");
    chk("R11 alert set", {7'b0, alert}, 8'h01);
    fin();
    ls[1] = 1; cov[0] = 1; cyc(); ls = '0; cov = '0;
    rd(2'd0, 8'h28, "R6 reg0 layout b");
    fin();
    tsd[1] = 1; toff[0] = 1; cyc(); tsd = '0; toff = '0;
    rd(2'd1, 8'h14, "R7 reg1 layout");
    fin();
    bst[1] = 1; cyc(); bst = '0;
    rd(2'd1, 8'h20, "R7 reg1 bootstrap ch1");
    fin();
    twarn = 1; v5a = 1; cerr = 1; cyc(); twarn = 0; v5a = 0; cerr = 0;
    rd(2'd2, 8'h0D, "R8 reg2 layout");
    fin();
    rd(2'd0, 8'h00, "R3 reg0 cleared");
    rd(2'd1, 8'h00, "R3 reg1 cleared");
    rd(2'd2, 8'h00, "R3 reg2 cleared");
  endtask

  task automatic t_sticky();
    ls[0] = 1; cyc(); ls = '0;
    repeat (6) cyc();
    rd(2'd0, 8'h02, "R2 sticky after condition gone");
    rd(2'd0, 8'h02, "R3 read command alone keeps flag");
    rd(2'd1, 8'h00, "R3 other register empty");
    fin();
    rd(2'd0, 8'h02, "R3 clear only in addressed register");
    fin();
    rd(2'd0, 8'h00, "R3 cleared after response end");
  endtask

  task automatic t_persist();
    tsd[0] = 1; cyc();
    rd(2'd1, 8'h01, "R4 persisting read");
    fin();
    tsd = '0; cyc();
    rd(2'd1, 8'h01, "R4 persisting flag kept");
    fin();
    rd(2'd1, 8'h00, "R4 cleared once gone");
    hs[1] = 1; cyc(); hs = '0;
    rd(2'd0, 8'h10, "R4 coincide setup");
    hs[1] = 1; rsp_end = 1; cyc(); hs = '0; rsp_end = 0;
    rd(2'd0, 8'h10, "R4 set wins over clear");
    fin();
  endtask

  task automatic t_late();
    rd(2'd1, 8'h00, "R5 empty snapshot");
    bst[0] = 1; cyc(); bst = '0;
    fin();
    rd(2'd1, 8'h02, "R5 late flag survives");
    fin();
    rd(2'd1, 8'h00, "R5 cleared on next read");
  endtask

  task automatic t_count();
    repeat (5) begin wdto = 1; cyc(); end
    wdto = 0;
    rd(2'd2, 8'h30, "R9 count saturates");
    fin();
    rd(2'd2, 8'h00, "R9 count cleared");
    fin();
    wdto = 1; cyc(); wdto = 0;
    rd(2'd2, 8'h10, "R9 one event");
    wdto = 1; cyc(); wdto = 0;
    fin();
    rd(2'd2, 8'h10, "R9 event after snapshot kept");
    wdto = 1; rsp_end = 1; cyc(); wdto = 0; rsp_end = 0;
    rd(2'd2, 8'h10, "R9 event in clearing cycle counted");
    fin();
  endtask

  task automatic t_addr3();
    cov[1] = 1; cyc(); cov = '0;
    rd(2'd3, 8'h00, "R10 address 3 reads zero");
    fin();
    fin();
    rd(2'd0, 8'h80, "R10 stray response end no effect");
    fin();
    rd(2'd0, 8'h00, "R10 final clear");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_layout();
    t_sticky();
    t_persist();
    t_late();
    t_count();
    t_addr3();
    summary();
  end
endmodule